// File: doc/BRIEF.md
# Retiming Path Matrix Engine

This block computes the all-pairs shortest-path data that a retiming solver needs for a signal-flow graph of up to N nodes. Software or a neighbouring controller writes, through a memory-style port, the register count of every edge and the computation time of every node. After a start pulse the engine turns each edge into a scaled weight that combines the register count with the time of the edge's source node. It then relaxes all pairs in place, one candidate path per clock cycle. Finally it converts every shortest distance into a minimum register count W and a worst combinational delay D for that node pair.

The W and D matrices, the raw distances and the edge entries can all be read back through the same port once the run ends. The engine also reports the largest and smallest finite D value, which bound the clock periods a retiming search has to try. A diagonal distance that ends below zero means the graph holds a loop with no register. That case raises an error flag instead of being solved.

Top module: `rt_path_matrix`

## Requirements
- R1: After reset, busy, done and the error flag are low, d_max is 0, d_min is the infinity marker (2^(DW-1)-1), every distance, W and D entry reads as the infinity marker, and every edge entry reads as -1 (no edge).
- R2: scale_m equals N times the largest node time; when all node times are zero the largest time is taken as 1.
- R3: At the start of a run, each distance entry (u,v) with u≠v is set to scale_m·w − t(u) when the edge entry w is zero or positive, and to infinity when it is negative. Diagonal entries are set to 0, and diagonal edge entries are ignored.
- R4: Relaxation visits k outermost, then i, then j. It replaces entry (i,j) by (i,k)+(k,j) only when neither term is infinity and the sum is strictly smaller, so a finite graph without zero-register loops ends with the true shortest distances.
- R5: For every node U, W(U,U) = 0 and D(U,U) = t(U).
- R6: For U≠V with a finite distance S, W(U,V) = ceil(S/scale_m) and D(U,V) = scale_m·W(U,V) − S + t(V). When S is infinity, both outputs hold the infinity marker.
- R7: The error flag rises during a run when any diagonal distance is negative after relaxation, and it is cleared by the next start.
- R8: At the end of a run, d_max and d_min hold the largest and smallest finite D entries, diagonal included. They do not change while the engine is idle.
- R9: done is high for exactly one cycle, N³+2N² clock edges after the edge that samples start, and busy falls right after it.
- R10: While busy, configuration writes and start pulses are ignored: edge entries, node times, scale_m and the run length stay unaffected.
- R11: The read port is combinational. rd_kind 0 selects distances, 1 selects W, 2 selects D and 3 selects raw edge entries. A write with cfg_kind 0 stores an edge entry at (cfg_row, cfg_col), and a write with cfg_kind 1 stores the time of node cfg_row from the low TW bits of the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a run when idle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0 edge register count, 1 node time |
| cfg_row | input | AW | Source node / node index |
| cfg_col | input | AW | Destination node |
| cfg_data | input | DW | Signed write data (negative edge = no edge) |
| rd_kind | input | 2 | Read matrix select |
| rd_row | input | AW | Read row |
| rd_col | input | AW | Read column |
| rd_data | output | DW | Selected entry |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| neg_cycle | output | 1 | Zero-register loop detected |
| d_max | output | DW | Largest finite D |
| d_min | output | DW | Smallest finite D |
| scale_m | output | DW | Scaling constant N·max t |

## Verification
Some properties are checked on every cycle: done lasts one cycle and busy falls only after it, scale_m holds steady through a run, d_min never exceeds d_max when done fires, the bounds and the error flag stay frozen while idle, and the flag rises only inside a run. The bench's scenarios show everything that depends on the actual numbers. They sweep several pseudo-random graphs whose zero-register edges run forward, a graph whose node times are all zero, a zero-register loop, and a run that is disturbed while busy. Each is compared with a full arithmetic model of the distances and of the W and D matrices, and the exact latency is counted in clock edges.

// File: rtl/rt_path_pkg.sv
package rt_path_pkg;
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_INIT  = 3'd1,
      PH_RELAX = 3'd2,
      PH_POST  = 3'd3,
      PH_FIN   = 3'd4
   } phase_t;
endpackage

// File: rtl/rt_path_seq.sv
module rt_path_seq
   import rt_path_pkg::*;
#(
   parameter int N  = 16,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output phase_t        phase,
   output logic [AW-1:0] k_o,
   output logic [AW-1:0] i_o,
   output logic [AW-1:0] j_o
);
   localparam logic [AW-1:0] LAST = AW'(N-1);
   localparam logic [AW-1:0] ONE  = AW'(1);

   logic end_row, end_sq, end_cube;
   assign end_row  = (j_o == LAST);
   assign end_sq   = end_row && (i_o == LAST);
   assign end_cube = end_sq && (k_o == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         k_o   <= '0;
         i_o   <= '0;
         j_o   <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase <= PH_INIT;
                  k_o   <= '0;
                  i_o   <= '0;
                  j_o   <= '0;
               end
            end
            PH_INIT, PH_POST: begin
               j_o <= end_row ? '0 : j_o + ONE;
               if (end_row) i_o <= end_sq ? '0 : i_o + ONE;
               if (end_sq)  phase <= (phase == PH_INIT) ? PH_RELAX : PH_FIN;
            end
            PH_RELAX: begin
               j_o <= end_row ? '0 : j_o + ONE;
               if (end_row)  i_o <= end_sq ? '0 : i_o + ONE;
               if (end_sq)   k_o <= end_cube ? '0 : k_o + ONE;
               if (end_cube) phase <= PH_POST;
            end
            PH_FIN:  phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rt_path_relax.sv
module rt_path_relax #(
   parameter int DW = 12
) (
   input  logic signed [DW-1:0] d_ik,
   input  logic signed [DW-1:0] d_kj,
   input  logic signed [DW-1:0] d_ij,
   output logic                 take,
   output logic signed [DW-1:0] sum_o
);
   localparam logic signed [DW-1:0] INF = {1'b0, {(DW-1){1'b1}}};

   logic signed [DW:0] sum, cur;
   assign sum   = {d_ik[DW-1], d_ik} + {d_kj[DW-1], d_kj};
   assign cur   = {d_ij[DW-1], d_ij};
   assign take  = (d_ik != INF) && (d_kj != INF) && (sum < cur);
   assign sum_o = DW'(sum);
endmodule

// File: rtl/rt_path_conv.sv
module rt_path_conv #(
   parameter int DW = 12,
   parameter int TW = 4
) (
   input  logic signed [DW-1:0] s,
   input  logic        [DW-1:0] m,
   input  logic        [TW-1:0] t_dst,
   input  logic                 diag,
   output logic signed [DW-1:0] w_o,
   output logic signed [DW-1:0] d_o,
   output logic                 fin_o
);
   localparam int XW = DW + 2;
   localparam logic signed [DW-1:0] INF = {1'b0, {(DW-1){1'b1}}};

   logic signed [XW-1:0] s_x, m_x, t_x, q, dv;
   logic        [XW-1:0] num, quot;

   always_comb begin
      s_x  = {{2{s[DW-1]}}, s};
      m_x  = {2'b00, m};
      t_x  = {{(XW-TW){1'b0}}, t_dst};
      num  = (s > 0) ? unsigned'(s_x + m_x - XW'(1)) : unsigned'(-s_x);
      quot = num / unsigned'(m_x);
      q    = (s > 0) ? signed'(quot) : -signed'(quot);
      dv   = m_x * q - s_x + t_x;
      if (diag) begin
         w_o   = '0;
         d_o   = DW'(t_x);
         fin_o = 1'b1;
      end else if (s == INF) begin
         w_o   = INF;
         d_o   = INF;
         fin_o = 1'b0;
      end else begin
         w_o   = DW'(q);
         d_o   = DW'(dv);
         fin_o = 1'b1;
      end
   end
endmodule

// File: rtl/rt_path_matrix.sv
module rt_path_matrix
   import rt_path_pkg::*;
#(
   parameter int N  = 16,
   parameter int DW = 12,
   parameter int TW = 4,
   localparam int AW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          cfg_we,
   input  logic          cfg_kind,
   input  logic [AW-1:0] cfg_row,
   input  logic [AW-1:0] cfg_col,
   input  logic [DW-1:0] cfg_data,
   input  logic [1:0]    rd_kind,
   input  logic [AW-1:0] rd_row,
   input  logic [AW-1:0] rd_col,
   output logic [DW-1:0] rd_data,
   output logic          busy,
   output logic          done,
   output logic          neg_cycle,
   output logic [DW-1:0] d_max,
   output logic [DW-1:0] d_min,
   output logic [DW-1:0] scale_m
);
   localparam logic signed [DW-1:0] INF = {1'b0, {(DW-1){1'b1}}};

   if (N < 2) begin : g_bad_n
      $error("rt_path_matrix: N must be at least 2");
   end
   if (TW >= DW - 1) begin : g_bad_tw
      $error("rt_path_matrix: TW must be well below DW");
   end
   if (N * (2**TW - 1) >= 2**(DW-1) - 1) begin : g_bad_scale
      $error("rt_path_matrix: N*max node time must stay below infinity");
   end

   logic signed [DW-1:0] s_mem [N][N];
   logic signed [DW-1:0] w_mem [N][N];
   logic signed [DW-1:0] d_mem [N][N];
   logic signed [DW-1:0] e_mem [N][N];
   logic        [TW-1:0] t_mem [N];

   phase_t        phase;
   logic [AW-1:0] k_i, i_i, j_i;

   rt_path_seq #(.N(N), .AW(AW)) seq_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .phase(phase), .k_o(k_i), .i_o(i_i), .j_o(j_i)
   );

   assign busy = (phase != PH_IDLE);
   assign done = (phase == PH_FIN);

   // scaling constant from the largest node time
   logic [TW-1:0] tmax;
   always_comb begin
      tmax = '0;
      for (int n = 0; n < N; n++)
         if (t_mem[n] > tmax) tmax = t_mem[n];
      if (tmax == '0) tmax = TW'(1);
   end
   assign scale_m = DW'(N) * {{(DW-TW){1'b0}}, tmax};

   // initial reweighted edge for entry (i,j)
   logic signed [DW-1:0] e_cur, init_v;
   always_comb begin
      e_cur = e_mem[i_i][j_i];
      if (i_i == j_i)      init_v = '0;
      else if (e_cur < 0)  init_v = INF;
      else                 init_v = signed'(scale_m) * e_cur
                                    - signed'({{(DW-TW){1'b0}}, t_mem[i_i]});
   end

   logic                 take;
   logic signed [DW-1:0] relax_v;
   rt_path_relax #(.DW(DW)) relax_i (
      .d_ik(s_mem[i_i][k_i]), .d_kj(s_mem[k_i][j_i]), .d_ij(s_mem[i_i][j_i]),
      .take(take), .sum_o(relax_v)
   );

   logic signed [DW-1:0] cw, cd;
   logic                 cfin;
   rt_path_conv #(.DW(DW), .TW(TW)) conv_i (
      .s(s_mem[i_i][j_i]), .m(scale_m), .t_dst(t_mem[j_i]),
      .diag(i_i == j_i), .w_o(cw), .d_o(cd), .fin_o(cfin)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < N; r++) begin
            t_mem[r] <= '0;
            for (int c = 0; c < N; c++) begin
               s_mem[r][c] <= INF;
               w_mem[r][c] <= INF;
               d_mem[r][c] <= INF;
               e_mem[r][c] <= '1;
            end
         end
         neg_cycle <= 1'b0;
         d_max     <= '0;
         d_min     <= INF;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (cfg_we && int'(cfg_row) < N) begin
                  if (!cfg_kind && int'(cfg_col) < N)
                     e_mem[cfg_row][cfg_col] <= cfg_data;
                  else if (cfg_kind)
                     t_mem[cfg_row] <= cfg_data[TW-1:0];
               end
               if (start) begin
                  neg_cycle <= 1'b0;
                  d_max     <= '0;
                  d_min     <= INF;
               end
            end
            PH_INIT:  s_mem[i_i][j_i] <= init_v;
            PH_RELAX: if (take) s_mem[i_i][j_i] <= relax_v;
            PH_POST: begin
               w_mem[i_i][j_i] <= cw;
               d_mem[i_i][j_i] <= cd;
               if (i_i == j_i && s_mem[i_i][j_i] < 0) neg_cycle <= 1'b1;
               if (cfin) begin
                  if (cd > signed'(d_max)) d_max <= cd;
                  if (cd < signed'(d_min)) d_min <= cd;
               end
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      if (int'(rd_row) < N && int'(rd_col) < N) begin
         case (rd_kind)
            2'd0:    rd_data = s_mem[rd_row][rd_col];
            2'd1:    rd_data = w_mem[rd_row][rd_col];
            2'd2:    rd_data = d_mem[rd_row][rd_col];
            default: rd_data = e_mem[rd_row][rd_col];
         endcase
      end
   end
endmodule

module rt_path_chk #(
   parameter int DW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          neg_cycle,
   input logic [DW-1:0] d_max,
   input logic [DW-1:0] d_min,
   input logic [DW-1:0] scale_m
);
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(done));
   // R10
   scale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(scale_m));
   // R8
   bound_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (signed'(d_min) <= signed'(d_max)));
   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy)) |-> ($stable(d_max) && $stable(d_min) && $stable(neg_cycle)));
   // R7
   flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(neg_cycle) |-> busy);
endmodule

bind rt_path_matrix rt_path_chk #(.DW(DW)) chk_i (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .neg_cycle(neg_cycle),
   .d_max(d_max), .d_min(d_min), .scale_m(scale_m)
);

// File: tb/rt_path_matrix_tb.sv
`timescale 1ns/1ps
module rt_path_matrix_tb_top;
   localparam int N   = 4;
   localparam int DW  = 12;
   localparam int TW  = 4;
   localparam int AW  = 2;
   localparam int INF = 2047;
   localparam int LAT = N*N*N + 2*N*N;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          cfg_we = 1'b0;
   logic          cfg_kind = 1'b0;
   logic [AW-1:0] cfg_row = '0, cfg_col = '0;
   logic [DW-1:0] cfg_data = '0;
   logic [1:0]    rd_kind = '0;
   logic [AW-1:0] rd_row = '0, rd_col = '0;
   logic signed [DW-1:0] rd_data;
   logic          busy, done, neg_cycle;
   logic signed [DW-1:0] d_max, d_min;
   logic [DW-1:0] scale_m;

   always #2 clk = ~clk;

   rt_path_matrix #(.N(N), .DW(DW), .TW(TW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
      .cfg_row(cfg_row), .cfg_col(cfg_col), .cfg_data(cfg_data),
      .rd_kind(rd_kind), .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data),
      .busy(busy), .done(done), .neg_cycle(neg_cycle),
      .d_max(d_max), .d_min(d_min), .scale_m(scale_m)
   );

   int checks = 0, errors = 0;
   bit finished = 0;
   int ew [N][N];
   int tn [N];
   int ms [N][N];
   int mw [N][N];
   int md [N][N];
   int mscale, mdmax, mdmin;
   bit mneg;
   int unsigned seed = 32'd12345;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int nxt();
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'((seed >> 16) & 32'h7fff);
   endfunction

   task automatic wr(input bit kind, input int r, input int c, input int v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_kind = kind; cfg_row = AW'(r); cfg_col = AW'(c); cfg_data = DW'(v);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input int kind, input int r, input int c, output int v);
      rd_kind = 2'(kind); rd_row = AW'(r); rd_col = AW'(c);
      #1 v = int'(rd_data);
   endtask

   task automatic program_graph();
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) wr(1'b0, i, j, ew[i][j]);
      for (int i = 0; i < N; i++) wr(1'b1, i, 0, tn[i]);
   endtask

   task automatic gen(input bit zero_times);
      for (int i = 0; i < N; i++) begin
         tn[i] = zero_times ? 0 : nxt() % 4;
         for (int j = 0; j < N; j++) begin
            int r;
            r = nxt() % 5;
            if (i == j)      ew[i][j] = 2;
            else if (r < 2)  ew[i][j] = -1;
            else begin
               ew[i][j] = r - 2;
               if (ew[i][j] == 0 && i > j) ew[i][j] = 1;
            end
         end
      end
   endtask

   task automatic model();
      int tm;
      tm = 0;
      for (int i = 0; i < N; i++) if (tn[i] > tm) tm = tn[i];
      if (tm == 0) tm = 1;
      mscale = N * tm;
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++)
            ms[i][j] = (i == j) ? 0 : (ew[i][j] < 0 ? INF : mscale * ew[i][j] - tn[i]);
      for (int k = 0; k < N; k++)
         for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
               if (ms[i][k] != INF && ms[k][j] != INF && ms[i][k] + ms[k][j] < ms[i][j])
                  ms[i][j] = ms[i][k] + ms[k][j];
      mneg = 0; mdmax = 0; mdmin = INF;
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) begin
            if (i == j) begin
               mw[i][j] = 0; md[i][j] = tn[i];
               if (ms[i][j] < 0) mneg = 1;
            end else if (ms[i][j] == INF) begin
               mw[i][j] = INF; md[i][j] = INF;
            end else begin
               mw[i][j] = (ms[i][j] > 0) ? (ms[i][j] + mscale - 1) / mscale
                                         : -((-ms[i][j]) / mscale);
               md[i][j] = mscale * mw[i][j] - ms[i][j] + tn[j];
            end
            if (md[i][j] != INF) begin
               if (md[i][j] > mdmax) mdmax = md[i][j];
               if (md[i][j] < mdmin) mdmin = md[i][j];
            end
         end
   endtask

   task automatic run(input bit inject);
      int cnt;
      @(negedge clk);
      start = 1'b1;
      @(posedge clk);
      cnt = 0;
      @(negedge clk);
      start = 1'b0;
      while (!done && cnt < LAT + 50) begin
         @(posedge clk);
         cnt++;
         @(negedge clk);
         if (inject && cnt == 5) begin
            cfg_we = 1'b1; cfg_kind = 1'b0; cfg_row = AW'(0); cfg_col = AW'(1);
            cfg_data = DW'(3); start = 1'b1;
         end
         if (inject && cnt == 6) begin
            cfg_kind = 1'b1; cfg_data = DW'(15);
         end
         if (inject && cnt == 7) begin
            cfg_we = 1'b0; start = 1'b0;
         end
      end
      chk(inject ? "R9 R10 latency" : "R9 latency", cnt, LAT);
      @(negedge clk);
      chk("R9 done width", int'(done), 0);
      chk("R9 busy after done", int'(busy), 0);
   endtask

   task automatic compare(input bit full);
      int v;
      chk("R2 scale", int'(scale_m), mscale);
      chk("R7 flag", int'(neg_cycle), int'(mneg));
      if (!full) return;
      chk("R8 dmax", int'(d_max), mdmax);
      chk("R8 dmin", int'(d_min), mdmin);
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) begin
            rd(0, i, j, v); chk("R3 R4 distance", v, ms[i][j]);
            rd(1, i, j, v); chk((i == j) ? "R5 W" : "R6 W", v, mw[i][j]);
            rd(2, i, j, v); chk((i == j) ? "R5 D" : "R6 D", v, md[i][j]);
            rd(3, i, j, v); chk("R11 edge", v, ew[i][j]);
         end
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 busy", int'(busy), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 flag", int'(neg_cycle), 0);
      chk("R1 dmax", int'(d_max), 0);
      chk("R1 dmin", int'(d_min), INF);
      rd(0, 1, 2, v); chk("R1 distance", v, INF);
      rd(1, 2, 3, v); chk("R1 W", v, INF);
      rd(2, 3, 0, v); chk("R1 D", v, INF);
      rd(3, 0, 3, v); chk("R1 R11 edge", v, -1);

      // R2 all node times zero
      gen(1'b1); program_graph(); model(); run(1'b0); compare(1'b1);

      // pseudo-random graphs, zero-register edges point forward
      for (int g = 0; g < 6; g++) begin
         gen(1'b0); program_graph(); model(); run(1'b0); compare(1'b1);
      end

      // R7 zero-register loop between nodes 0 and 1
      for (int i = 0; i < N; i++) begin
         tn[i] = 1;
         for (int j = 0; j < N; j++) ew[i][j] = -1;
      end
      ew[0][1] = 0; ew[1][0] = 0;
      program_graph(); model(); run(1'b0);
      chk("R7 loop flag", int'(neg_cycle), 1);
      compare(1'b0);

      // R10 writes and start during a run
      gen(1'b0); program_graph(); model(); run(1'b1); compare(1'b1);
      rd(3, 0, 1, v); chk("R10 edge kept", v, ew[0][1]);
      // R7 flag cleared by the next start on a loop-free graph
      chk("R7 cleared", int'(neg_cycle), 0);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule